// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short queue of 8-bit completion records for transmitted frames. When the transmit engine finishes a frame, it reports the frame's outcome. A record is kept only if the host needs to see that frame: either the frame ended in an error, or the host asked for an interrupt on success. The host reads the record at the head through a byte-wide status port. A write strobe to that port removes the head.

When a record arrives and every entry is already in use, the block discards the new record and flags the loss in the byte it presents. A jabber or underrun outcome stops further transmission until a transmit reset. That reset also empties the queue and clears the loss flag. The completion-event output stays high while any record is waiting, so it can feed an interrupt status bit.

Top module: `txstat_stack`

## Requirements
- R1: A kept record reads bit 7 = 1 (complete), bit 6 = success-interrupt request, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, and bits 1:0 = 0.
- R2: A frame report (`frame_done` high) is kept only if at least one of `irq_on_ok`, `err_jabber`, `err_underrun` or `err_maxcoll` is set. Any other report leaves the contents and the read value unchanged.
- R3: A cycle with `host_pop` high removes the head record. `host_pop` while the queue is empty has no effect.
- R4: While the queue is empty, `status_rd` reads 0x00.
- R5: With `LIFO_MODE` = 0 (the default), records are presented oldest first. With `LIFO_MODE` = 1, the newest record is presented first.
- R6: A kept record that arrives while all `DEPTH` entries are full, with no pop in that cycle, is discarded. Bit 2 of `status_rd` then reads 1 until the next pop.
- R7: A pop and a kept record in the same cycle while the queue is full both take effect. No record is lost, and bit 2 is not set.
- R8: `tx_reset` (and `rst`) empties the queue and clears both the overflow flag and `tx_halted`. It takes priority over a pop or a frame report in the same cycle.
- R9: `txc_event` is high exactly when at least one record is held.
- R10: `tx_halted` goes high in the cycle after a frame report with jabber or underrun set. It stays high until `tx_reset`.
- R11: The queue holds `DEPTH` records (default 4) before it overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | Transmit engine finished a frame this cycle |
| irq_on_ok | input | 1 | Frame requested an interrupt on success |
| err_jabber | input | 1 | Frame ended in a jabber error |
| err_underrun | input | 1 | Frame ended in an underrun |
| err_maxcoll | input | 1 | Frame hit the collision limit |
| host_pop | input | 1 | Host write strobe to the status byte |
| tx_reset | input | 1 | Transmit reset command |
| status_rd | output | 8 | Head record with the overflow flag merged into bit 2 |
| txc_event | output | 1 | Records are waiting |
| tx_halted | output | 1 | Transmission blocked until a transmit reset |

## Verification
A host pop and a new frame report can land in the same cycle. The case that matters is when the queue is full, because there the outcome decides whether a record is lost. The bench fills all entries and then drives a pop together with a qualifying report. It then checks the following against the reference model on every cycle:
- the head advances;
- the new record is placed at the tail;
- bit 2 stays clear.

It also drives `tx_reset` together with a report and a pop, to confirm that the reset wins.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

    typedef struct packed {
        logic       complete;
        logic       irq_req;
        logic       jabber;
        logic       underrun;
        logic       max_coll;
        logic       overflow;
        logic [1:0] unused;
    } txstat_rec_t;

    typedef struct packed {
        logic valid;
        logic irq_req;
        logic jabber;
        logic underrun;
        logic max_coll;
    } frame_rpt_t;

    function automatic logic rpt_keeps(input frame_rpt_t r);
        return r.valid & (r.irq_req | r.jabber | r.underrun | r.max_coll);
    endfunction

    function automatic txstat_rec_t rpt_to_rec(input frame_rpt_t r);
        txstat_rec_t t;
        t.complete = 1'b1;
        t.irq_req  = r.irq_req;
        t.jabber   = r.jabber;
        t.underrun = r.underrun;
        t.max_coll = r.max_coll;
        t.overflow = 1'b0;
        t.unused   = 2'b00;
        return t;
    endfunction

    function automatic logic rpt_halts(input frame_rpt_t r);
        return r.valid & (r.jabber | r.underrun);
    endfunction

endpackage

// File: rtl/txstat_filter.sv
module txstat_filter
    import txstat_pkg::*;
(
    input  frame_rpt_t  rpt,
    output logic        keep,
    output logic        halt_evt,
    output txstat_rec_t rec
);
    always_comb begin
        keep     = rpt_keeps(rpt);
        halt_evt = rpt_halts(rpt);
        rec      = rpt_to_rec(rpt);
    end
endmodule

// File: rtl/txstat_store.sv
module txstat_store
    import txstat_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter bit LIFO_MODE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        do_push,
    input  logic        do_pop,
    input  txstat_rec_t din,
    output txstat_rec_t head,
    output logic        empty,
    output logic        full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);
    localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);

    txstat_rec_t    mem [DEPTH];
    logic [CW-1:0]  cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CMAX);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (do_push && !do_pop)
            cnt <= cnt + 1'b1;
        else if (do_pop && !do_push)
            cnt <= cnt - 1'b1;
    end

    generate
        if (LIFO_MODE) begin : g_lifo
            logic [AW-1:0] top_idx;
            logic [AW-1:0] nxt_idx;
            assign top_idx = AW'(cnt - 1'b1);
            assign nxt_idx = AW'(cnt);
            always_ff @(posedge clk) begin
                if (do_push && do_pop)
                    mem[top_idx] <= din;
                else if (do_push)
                    mem[nxt_idx] <= din;
            end
            assign head = mem[top_idx];
        end else begin : g_fifo
            logic [AW-1:0] rd_ptr, wr_ptr;
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    rd_ptr <= '0;
                    wr_ptr <= '0;
                end else begin
                    if (do_push) begin
                        mem[wr_ptr] <= din;
                        wr_ptr <= (wr_ptr == ALAST) ? '0 : wr_ptr + 1'b1;
                    end
                    if (do_pop)
                        rd_ptr <= (rd_ptr == ALAST) ? '0 : rd_ptr + 1'b1;
                end
            end
            assign head = mem[rd_ptr];
        end
    endgenerate

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CMAX);

    // R3
    pop_dec_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (do_pop && !do_push) |=> (cnt == $past(cnt) - 1'b1));

    // R11
    push_inc_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (do_push && !do_pop) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
    import txstat_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter bit LIFO_MODE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_done,
    input  logic       irq_on_ok,
    input  logic       err_jabber,
    input  logic       err_underrun,
    input  logic       err_maxcoll,
    input  logic       host_pop,
    input  logic       tx_reset,
    output logic [7:0] status_rd,
    output logic       txc_event,
    output logic       tx_halted
);
    frame_rpt_t  rpt;
    txstat_rec_t new_rec, head_rec, shown;
    logic        keep, halt_evt, empty, full;
    logic        pop_eff, push_eff, drop, ovf_q;

    assign rpt = '{valid: frame_done, irq_req: irq_on_ok, jabber: err_jabber,
                   underrun: err_underrun, max_coll: err_maxcoll};

    txstat_filter u_filter (
        .rpt      (rpt),
        .keep     (keep),
        .halt_evt (halt_evt),
        .rec      (new_rec)
    );

    assign pop_eff  = host_pop && !empty && !tx_reset;
    assign push_eff = keep && (!full || pop_eff) && !tx_reset;
    assign drop     = keep && full && !pop_eff && !tx_reset;

    txstat_store #(.DEPTH(DEPTH), .LIFO_MODE(LIFO_MODE)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (tx_reset),
        .do_push (push_eff),
        .do_pop  (pop_eff),
        .din     (new_rec),
        .head    (head_rec),
        .empty   (empty),
        .full    (full)
    );

    always_ff @(posedge clk) begin
        if (rst || tx_reset)
            ovf_q <= 1'b0;
        else if (drop)
            ovf_q <= 1'b1;
        else if (pop_eff)
            ovf_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || tx_reset)
            tx_halted <= 1'b0;
        else if (halt_evt)
            tx_halted <= 1'b1;
    end

    always_comb begin
        shown          = head_rec;
        shown.overflow = ovf_q;
        status_rd      = empty ? 8'h00 : shown;
        txc_event      = !empty;
    end

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !txc_event |-> (status_rd == 8'h00));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        tx_reset |=> (!txc_event && !tx_halted));

    // R6
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst || tx_reset)
        (frame_done && err_maxcoll && full && !host_pop) |=> status_rd[2]);

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_halted && !tx_reset) |=> tx_halted);

    // R1
    rec_low_chk: assert property (@(posedge clk) disable iff (rst)
        txc_event |-> (status_rd[7] && status_rd[1:0] == 2'b00));
endmodule

// File: tb/txstat_stack_tb.sv
module txstat_stack_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst, frame_done, irq_on_ok, err_jabber, err_underrun, err_maxcoll;
    logic host_pop, tx_reset;
    logic [7:0] status_rd;
    logic txc_event, tx_halted;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    byte unsigned q[$];
    bit m_ovf = 0;
    bit m_halt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txstat_stack #(.DEPTH(DEPTH), .LIFO_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .frame_done(frame_done), .irq_on_ok(irq_on_ok),
        .err_jabber(err_jabber), .err_underrun(err_underrun),
        .err_maxcoll(err_maxcoll), .host_pop(host_pop), .tx_reset(tx_reset),
        .status_rd(status_rd), .txc_event(txc_event), .tx_halted(tx_halted)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int exp_rd;
        exp_rd = (q.size() == 0) ? 0 : (int'(q[0]) | (int'(m_ovf) << 2));
        chk({tag, " status_rd"}, status_rd, exp_rd);
        chk({tag, " txc_event R9"}, txc_event, q.size() != 0);
        chk({tag, " tx_halted R10"}, tx_halted, m_halt);
    endtask

    task automatic cyc(input bit dv, input bit irq, input bit jab, input bit und,
                       input bit mc, input bit pop, input bit trst, input string tag);
        bit acc, pe, full;
        frame_done = dv; irq_on_ok = irq; err_jabber = jab;
        err_underrun = und; err_maxcoll = mc; host_pop = pop; tx_reset = trst;
        if (trst) begin
            q.delete(); m_ovf = 0; m_halt = 0;
        end else begin
            acc  = dv && (irq || jab || und || mc);
            pe   = pop && (q.size() > 0);
            full = (q.size() == DEPTH);
            if (pe) begin void'(q.pop_front()); m_ovf = 0; end
            if (acc) begin
                if (!full || pe) q.push_back(8'h80 | (irq << 6) | (jab << 5) | (und << 4) | (mc << 3));
                else m_ovf = 1;
            end
            if (dv && (jab || und)) m_halt = 1;
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; frame_done = 0; irq_on_ok = 0; err_jabber = 0; err_underrun = 0;
        err_maxcoll = 0; host_pop = 0; tx_reset = 0;
        repeat (2) @(posedge clk);
        #1; rst = 0;
        compare("R4 reset");
        // R1 R10: jabber frame kept and halts
        cyc(1,0,1,0,0,0,0, "R1 jabber");
        chk("R1 byte", status_rd, 8'hA0);
        // R3 pop
        cyc(0,0,0,0,0,1,0, "R3 pop");
        cyc(0,0,0,0,0,1,0, "R3 pop-empty");
        // R2 non-qualifying frame ignored
        cyc(1,0,0,0,0,0,0, "R2 plain frame");
        chk("R2 empty", status_rd, 0);
        cyc(1,1,0,0,0,0,0, "R2 irq frame");
        cyc(1,0,0,0,0,0,0, "R2 plain while held");
        cyc(0,0,0,0,0,1,0, "R3 pop");
        // R5 R11 fill in order, then overflow R6
        cyc(1,1,0,0,0,0,0, "R11 fill");
        cyc(1,0,0,1,0,0,0, "R11 fill");
        cyc(1,0,0,0,1,0,0, "R11 fill");
        cyc(1,1,0,0,1,0,0, "R11 fill");
        cyc(1,0,0,0,1,0,0, "R6 overflow");
        chk("R6 bit2", status_rd[2], 1);
        cyc(0,0,0,0,0,0,0, "R6 hold");
        cyc(0,0,0,0,0,1,0, "R5 order pop");
        chk("R6 cleared", status_rd[2], 0);
        cyc(1,0,0,0,1,0,0, "R11 refill");
        // R7 full + simultaneous pop and push
        cyc(1,1,0,0,0,1,0, "R7 pop+push full");
        chk("R7 no ovf", status_rd[2], 0);
        for (int i = 0; i < DEPTH; i++) cyc(0,0,0,0,0,1,0, "R5 drain");
        chk("R4 drained", status_rd, 0);
        // R8 reset priority
        cyc(1,0,0,0,1,0,0, "R8 load");
        cyc(1,0,0,0,1,0,0, "R8 load");
        cyc(1,0,0,1,0,1,1, "R8 reset wins");
        chk("R8 empty", txc_event, 0);
        cyc(1,1,0,0,0,0,0, "R8 after");
        cyc(0,0,0,0,0,0,1, "R8 clear");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule